// File: doc/BRIEF.md
# First-Order Lead Compensation Filter

This block produces a motor drive command once per sample period from a programmable first-order lead compensator. A sample strobe from an external sample-rate timer starts each computation. On the strobe the block takes the difference between a commanded and a measured value (positions in position mode, velocities in velocity mode). It limits that error to 16 signed bits and latches it together with the zero coefficient A, the pole coefficient B and the gain K. Three clock edges later it presents a saturated 8-bit signed command with a one-cycle valid pulse.

In position mode the new command is the gained current error, less a zero term formed from the gained previous error and a pole term formed from the previous command: `MC = floor(K*X/4) - floor(A*floor(K*Xp/4)/256) - floor(B*MCp/256)`. In velocity mode the command is only `floor(K*Y/4)`. Every divide rounds toward negative infinity. The stored previous error and previous command are cleared by the clear strobe, which the host raises when the loop enters its init/idle state.

A small state machine sequences the work. `ST_IDLE` waits for a strobe; the transition ST_IDLE→ST_PROD is taken on an accepted strobe. In `ST_PROD` the gain and pole products are formed, then the unconditional transition ST_PROD→ST_ACC follows. In `ST_ACC` the zero product and the final sum are formed, the output and history are written, and the unconditional transition ST_ACC→ST_IDLE follows. The clear strobe forces any state back to ST_IDLE.

Top module: `lead_comp_filter`

## Requirements
- R1: In position mode (`vel_mode_i`=0) the result is sat8(floor(K*X/4) - floor(A*floor(K*Xp/4)/256) - floor(B*MCp/256)). X is the saturated error of this sample, Xp the stored previous error and MCp the stored previous result, and each divide rounds toward negative infinity.
- R2: In velocity mode (`vel_mode_i`=1) the result is sat8(floor(K*Y/4)) with Y the saturated error, whatever the stored history holds.
- R3: The error `cmd_i - act_i` is limited to the range -32768..32767 before any multiplication.
- R4: The result is limited to -128..127, and that limited value, together with the limited error, becomes the history for the next sample in either mode.
- R5: A, B, K and the mode are sampled at the accepted strobe. Changing them during a computation does not affect that result, and the new values are used by the next computation.
- R6: A clear pulse (`clr_i`=1 at an edge) zeroes both history values and `mc_o`, cancels any computation in progress (no valid pulse follows), and takes priority over a strobe at the same edge.
- R7: `mc_valid_o` is high for exactly one cycle, in the cycle after the third rising edge counted from the edge that accepted the strobe. `mc_o` changes only with that pulse or with a clear.
- R8: A strobe that arrives while a computation is in progress (states ST_PROD or ST_ACC) is ignored and produces no extra result.
- R9: After reset `mc_o` is 0, `mc_valid_o` is 0 and both history values are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | 1 | Sample strobe starting one computation |
| clr_i | input | 1 | Clears history and output, cancels a computation |
| vel_mode_i | input | 1 | 0 = position lead filter, 1 = proportional velocity |
| cmd_i | input | IN_W | Signed commanded position or velocity |
| act_i | input | IN_W | Signed measured position or velocity |
| coef_a_i | input | 8 | Unsigned zero coefficient A |
| coef_b_i | input | 8 | Unsigned pole coefficient B |
| coef_k_i | input | 8 | Unsigned gain K |
| mc_o | output | 8 | Signed saturated motor command |
| mc_valid_o | output | 1 | One-cycle pulse marking a new `mc_o` |

## Verification
The hardest situations to reach from the ports are a second strobe or a coefficient change landing in the middle of the three-edge computation, and a clear landing while a result is still pending. The stimulus reaches them by driving these inputs at chosen falling edges between the accepting edge and the result edge. A bench model that keeps its own history predicts the result, which must show that the intruding inputs changed nothing. Long position-mode sequences with random coefficients carry the history through many samples. Sweeps in velocity mode over gain and error, together with extreme positions, drive both saturation stages at their limits.

// File: rtl/lcf_pkg.sv
package lcf_pkg;

    localparam int ERR_W  = 16;
    localparam int MC_W   = 8;
    localparam int COEF_W = 8;
    localparam int KX_W   = ERR_W + COEF_W + 1 - 2;
    localparam int BM_W   = MC_W + COEF_W + 1 - 8;
    localparam int PA_W   = KX_W + COEF_W + 1 - 8;
    localparam int SUM_W  = 40;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROD = 2'd1,
        ST_ACC  = 2'd2
    } lcf_state_e;

    function automatic logic signed [MC_W-1:0] sat_mc(input logic signed [SUM_W-1:0] v);
        logic signed [SUM_W-1:0] hi;
        logic signed [SUM_W-1:0] lo;
        hi = SUM_W'((1 <<< (MC_W - 1)) - 1);
        lo = -SUM_W'(1 <<< (MC_W - 1));
        if (v > hi)
            return hi[MC_W-1:0];
        else if (v < lo)
            return lo[MC_W-1:0];
        else
            return v[MC_W-1:0];
    endfunction

endpackage

// File: rtl/lcf_ctrl.sv
module lcf_ctrl
    import lcf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_i,
    input  logic clr_i,
    output logic accept_o,
    output logic prod_o,
    output logic acc_o
);

    lcf_state_e state_q;
    lcf_state_e state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: state_n = sample_i ? ST_PROD : ST_IDLE;
            ST_PROD: state_n = ST_ACC;
            ST_ACC:  state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else if (clr_i)
            state_q <= ST_IDLE;
        else
            state_q <= state_n;
    end

    always_comb begin
        accept_o = 1'b0;
        prod_o   = 1'b0;
        acc_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: accept_o = sample_i && !clr_i;
            ST_PROD: prod_o   = !clr_i;
            ST_ACC:  acc_o    = !clr_i;
            default: ;
        endcase
    end

    // R8: a busy state always runs to completion, strobes cannot restart it
    p_prod_to_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROD && !clr_i) |=> (state_q == ST_ACC));
    p_acc_to_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACC && !clr_i) |=> (state_q == ST_IDLE));
    // R6: clear always returns to idle
    p_clear_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/lcf_capture.sv
module lcf_capture
    import lcf_pkg::*;
#(
    parameter int IN_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     accept_i,
    input  logic                     vel_mode_i,
    input  logic signed [IN_W-1:0]   cmd_i,
    input  logic signed [IN_W-1:0]   act_i,
    input  logic        [COEF_W-1:0] coef_a_i,
    input  logic        [COEF_W-1:0] coef_b_i,
    input  logic        [COEF_W-1:0] coef_k_i,
    output logic signed [ERR_W-1:0]  err_q_o,
    output logic        [COEF_W-1:0] a_q_o,
    output logic        [COEF_W-1:0] b_q_o,
    output logic        [COEF_W-1:0] k_q_o,
    output logic                     vel_q_o
);

    localparam int DW = IN_W + 1;

    logic signed [DW-1:0]    diff;
    logic signed [ERR_W-1:0] err_lim;

    assign diff = DW'(cmd_i) - DW'(act_i);

    generate
        if (DW > ERR_W) begin : g_limit
            localparam logic signed [DW-1:0] EMAX = DW'((1 <<< (ERR_W - 1)) - 1);
            localparam logic signed [DW-1:0] EMIN = -DW'(1 <<< (ERR_W - 1));
            always_comb begin
                if (diff > EMAX)
                    err_lim = EMAX[ERR_W-1:0];
                else if (diff < EMIN)
                    err_lim = EMIN[ERR_W-1:0];
                else
                    err_lim = diff[ERR_W-1:0];
            end
        end else begin : g_extend
            assign err_lim = ERR_W'(diff);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q_o <= '0;
            a_q_o   <= '0;
            b_q_o   <= '0;
            k_q_o   <= '0;
            vel_q_o <= 1'b0;
        end else if (accept_i) begin
            err_q_o <= err_lim;
            a_q_o   <= coef_a_i;
            b_q_o   <= coef_b_i;
            k_q_o   <= coef_k_i;
            vel_q_o <= vel_mode_i;
        end
    end

    // R5: latched settings hold while no strobe is accepted
    p_coef_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(accept_i) |-> ($stable(k_q_o) && $stable(a_q_o) && $stable(b_q_o) && $stable(err_q_o)));

endmodule

// File: rtl/lcf_datapath.sv
module lcf_datapath
    import lcf_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr_i,
    input  logic                     prod_i,
    input  logic                     acc_i,
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic        [COEF_W-1:0] a_i,
    input  logic        [COEF_W-1:0] b_i,
    input  logic        [COEF_W-1:0] k_i,
    input  logic                     vel_i,
    output logic signed [MC_W-1:0]   mc_o,
    output logic                     mc_valid_o
);

    logic signed [ERR_W-1:0]          xprev_q;
    logic signed [MC_W-1:0]           mcprev_q;
    logic signed [KX_W-1:0]           kx_q;
    logic signed [KX_W-1:0]           kxp_q;
    logic signed [BM_W-1:0]           bm_q;

    logic signed [ERR_W+COEF_W:0]     prod_k;
    logic signed [ERR_W+COEF_W:0]     prod_kp;
    logic signed [MC_W+COEF_W:0]      prod_b;
    logic signed [KX_W+COEF_W:0]      prod_a;
    logic signed [PA_W-1:0]           pa;
    logic signed [SUM_W-1:0]          sum_pos;
    logic signed [SUM_W-1:0]          sum_sel;
    logic signed [MC_W-1:0]           res;

    // first stage: gain and pole products, floor by slicing off low bits
    always_comb begin
        prod_k  = $signed({1'b0, k_i}) * err_i;
        prod_kp = $signed({1'b0, k_i}) * xprev_q;
        prod_b  = $signed({1'b0, b_i}) * mcprev_q;
    end

    // second stage: zero product, sum and limit
    always_comb begin
        prod_a  = $signed({1'b0, a_i}) * kxp_q;
        pa      = prod_a[KX_W+COEF_W:8];
        sum_pos = SUM_W'(kx_q) - SUM_W'(pa) - SUM_W'(bm_q);
        sum_sel = vel_i ? SUM_W'(kx_q) : sum_pos;
        res     = sat_mc(sum_sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xprev_q    <= '0;
            mcprev_q   <= '0;
            kx_q       <= '0;
            kxp_q      <= '0;
            bm_q       <= '0;
            mc_o       <= '0;
            mc_valid_o <= 1'b0;
        end else if (clr_i) begin
            xprev_q    <= '0;
            mcprev_q   <= '0;
            mc_o       <= '0;
            mc_valid_o <= 1'b0;
        end else begin
            mc_valid_o <= acc_i;
            if (prod_i) begin
                kx_q  <= prod_k[ERR_W+COEF_W:2];
                kxp_q <= prod_kp[ERR_W+COEF_W:2];
                bm_q  <= prod_b[MC_W+COEF_W:8];
            end
            if (acc_i) begin
                mc_o     <= res;
                mcprev_q <= res;
                xprev_q  <= err_i;
            end
        end
    end

    // R6: history is zero right after a clear
    p_clear_hist_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i) |-> (xprev_q == '0 && mcprev_q == '0 && mc_o == '0));
    // R4: the stored previous command is the value presented
    p_hist_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mc_valid_o |-> (mcprev_q == mc_o && xprev_q == err_i));
    // R7: valid is a single-cycle pulse
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mc_valid_o |=> !mc_valid_o);

endmodule

// File: rtl/lead_comp_filter.sv
module lead_comp_filter
    import lcf_pkg::*;
#(
    parameter int IN_W = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_i,
    input  logic                     clr_i,
    input  logic                     vel_mode_i,
    input  logic signed [IN_W-1:0]   cmd_i,
    input  logic signed [IN_W-1:0]   act_i,
    input  logic        [COEF_W-1:0] coef_a_i,
    input  logic        [COEF_W-1:0] coef_b_i,
    input  logic        [COEF_W-1:0] coef_k_i,
    output logic signed [MC_W-1:0]   mc_o,
    output logic                     mc_valid_o
);

    logic                     accept;
    logic                     prod;
    logic                     acc;
    logic signed [ERR_W-1:0]  err_q;
    logic        [COEF_W-1:0] a_q;
    logic        [COEF_W-1:0] b_q;
    logic        [COEF_W-1:0] k_q;
    logic                     vel_q;

    lcf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .clr_i    (clr_i),
        .accept_o (accept),
        .prod_o   (prod),
        .acc_o    (acc)
    );

    lcf_capture #(.IN_W(IN_W)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .vel_mode_i (vel_mode_i),
        .cmd_i      (cmd_i),
        .act_i      (act_i),
        .coef_a_i   (coef_a_i),
        .coef_b_i   (coef_b_i),
        .coef_k_i   (coef_k_i),
        .err_q_o    (err_q),
        .a_q_o      (a_q),
        .b_q_o      (b_q),
        .k_q_o      (k_q),
        .vel_q_o    (vel_q)
    );

    lcf_datapath u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr_i),
        .prod_i     (prod),
        .acc_i      (acc),
        .err_i      (err_q),
        .a_i        (a_q),
        .b_i        (b_q),
        .k_i        (k_q),
        .vel_i      (vel_q),
        .mc_o       (mc_o),
        .mc_valid_o (mc_valid_o)
    );

    // R7: every result traces back to a strobe accepted three edges earlier
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mc_valid_o |-> $past(accept, 3));
    // R7: output only moves with a result or a clear
    p_mc_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mc_valid_o && !$past(clr_i)) |-> $stable(mc_o));

endmodule

// File: tb/lead_comp_filter_tb_top.sv
`timescale 1ns/1ps
module lead_comp_filter_tb_top;

    localparam int IN_W = 24;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   sample_i = 1'b0;
    logic                   clr_i = 1'b0;
    logic                   vel_mode_i = 1'b0;
    logic signed [IN_W-1:0] cmd_i = '0;
    logic signed [IN_W-1:0] act_i = '0;
    logic [7:0]             coef_a_i = '0;
    logic [7:0]             coef_b_i = '0;
    logic [7:0]             coef_k_i = '0;
    logic signed [7:0]      mc_o;
    logic                   mc_valid_o;

    int n_vec  = 0;
    int n_fail = 0;
    int m_xp   = 0;
    int m_mp   = 0;
    int m_last = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    lead_comp_filter #(.IN_W(IN_W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (sample_i),
        .clr_i      (clr_i),
        .vel_mode_i (vel_mode_i),
        .cmd_i      (cmd_i),
        .act_i      (act_i),
        .coef_a_i   (coef_a_i),
        .coef_b_i   (coef_b_i),
        .coef_k_i   (coef_k_i),
        .mc_o       (mc_o),
        .mc_valid_o (mc_valid_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int sat(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // model of R1..R4, updates model history
    function automatic int model(input int cmd, input int act, input int a, input int b,
                                 input int k, input bit vel);
        int e, kx, kxp, p, q, r;
        e  = sat(cmd - act, -32768, 32767);
        kx = (k * e) >>> 2;
        if (vel) begin
            r = sat(kx, -128, 127);
        end else begin
            kxp = (k * m_xp) >>> 2;
            p   = (a * kxp) >>> 8;
            q   = (b * m_mp) >>> 8;
            r   = sat(kx - p - q, -128, 127);
        end
        m_xp = e;
        m_mp = r;
        return r;
    endfunction

    // one sample; intrude=1 adds a busy strobe and coefficient change (R5, R8)
    task automatic run(input int cmd, input int act, input int a, input int b,
                       input int k, input bit vel, input bit intrude, input string req);
        int exp;
        exp = model(cmd, act, a, b, k, vel);
        @(negedge clk);
        cmd_i = IN_W'(cmd); act_i = IN_W'(act);
        coef_a_i = 8'(a); coef_b_i = 8'(b); coef_k_i = 8'(k);
        vel_mode_i = vel; sample_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_i = intrude;
        if (intrude) begin
            cmd_i = IN_W'(cmd + 777); coef_k_i = 8'(k ^ 8'h5A);
            coef_a_i = 8'(a ^ 8'hC3); coef_b_i = 8'(b ^ 8'h3C); vel_mode_i = !vel;
        end
        chk(mc_valid_o == 1'b0, "R7 early valid", int'(mc_valid_o), 0);
        @(posedge clk);
        @(negedge clk);
        sample_i = 1'b0;
        chk(mc_o == 8'(m_last), "R7 output moved early", int'(mc_o), m_last);
        @(posedge clk);
        @(negedge clk);
        chk(mc_valid_o == 1'b1, "R7 valid missing", int'(mc_valid_o), 1);
        chk(int'(mc_o) == exp, req, int'(mc_o), exp);
        @(posedge clk);
        @(negedge clk);
        chk(mc_valid_o == 1'b0, intrude ? "R8 extra result" : "R7 pulse width", int'(mc_valid_o), 0);
        chk(int'(mc_o) == exp, "R7 output hold", int'(mc_o), exp);
        m_last = exp;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_i = 1'b0;
        m_xp = 0; m_mp = 0; m_last = 0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_vec++; n_fail++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(mc_o == 8'sd0, "R9 reset output", int'(mc_o), 0);
        chk(mc_valid_o == 1'b0, "R9 reset valid", int'(mc_valid_o), 0);
        // R9 zero history: first position result sees no previous terms
        run(100, 0, 255, 255, 8, 1'b0, 1'b0, "R9 first sample history");
        run(-50, 10, 200, 128, 16, 1'b0, 1'b0, "R1 position second sample");

        // R2 near-exhaustive velocity sweep, history nonzero but unused
        for (int ki = 0; ki < 9; ki++) begin
            for (int e = -600; e <= 600; e += 75) begin
                run(e, 0, 255, 255, (ki * 32 > 255) ? 255 : ki * 32, 1'b1, 1'b0, "R2 velocity");
            end
        end

        // R3 error limiting at both ends, R4 output limiting
        run(4000000, -4000000, 0, 0, 1, 1'b1, 1'b0, "R3 error clamp high");
        run(-4000000, 4000000, 0, 0, 1, 1'b1, 1'b0, "R3 error clamp low");
        run(32767 + 4, 0, 0, 0, 2, 1'b1, 1'b0, "R3 clamp small gain");
        run(8388607, -8388608, 255, 255, 255, 1'b0, 1'b0, "R4 saturate high");
        run(-8388608, 8388607, 255, 255, 255, 1'b0, 1'b0, "R4 saturate low");
        run(3, 0, 255, 255, 4, 1'b0, 1'b0, "R4 saturated history used");

        // R1 long position sequences, random coefficients and small errors
        for (int i = 0; i < 600; i++) begin
            run($signed($urandom_range(0, 2000)) - 1000, $signed($urandom_range(0, 400)) - 200,
                $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
                (i % 10) == 9, 1'b0, "R1 position sequence");
        end

        // R5 and R8: intruding strobe and coefficient change mid computation
        for (int i = 0; i < 40; i++) begin
            run($signed($urandom_range(0, 600)) - 300, 0,
                $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
                1'b0, 1'b1, "R5 coefficients latched");
            run(i * 7 - 140, 0, 96, 160, 64, 1'b0, 1'b0, "R5 new values next sample");
        end

        // R6 clear zeroes history and output
        run(500, 0, 128, 128, 100, 1'b0, 1'b0, "R1 before clear");
        pulse_clear();
        chk(mc_o == 8'sd0, "R6 output cleared", int'(mc_o), 0);
        run(40, 0, 255, 255, 20, 1'b0, 1'b0, "R6 history cleared");

        // R6 clear during computation cancels it
        @(negedge clk);
        cmd_i = 24'sd900; act_i = '0; coef_k_i = 8'd50; vel_mode_i = 1'b0; sample_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_i = 1'b0; clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr_i = 1'b0;
        m_xp = 0; m_mp = 0; m_last = 0;
        for (int c = 0; c < 4; c++) begin
            chk(mc_valid_o == 1'b0, "R6 cancelled result", int'(mc_valid_o), 0);
            chk(mc_o == 8'sd0, "R6 output after cancel", int'(mc_o), 0);
            @(negedge clk);
        end
        // R6 clear wins over a strobe at the same edge
        sample_i = 1'b1; clr_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sample_i = 1'b0; clr_i = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk(mc_valid_o == 1'b0, "R6 clear priority", int'(mc_valid_o), 0);
            @(negedge clk);
        end
        run(-30, 0, 10, 250, 90, 1'b0, 1'b0, "R6 fresh start after cancel");

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule